// File: doc/BRIEF.md
# Shared interrupt affinity router

This block holds the routing setting of every shared interrupt in an interrupt controller. Software writes a 32-bit affinity value into a 64-bit routing slot per shared interrupt. The block keeps that value for read-back. It also looks the value up in a table that lists the affinity of each CPU. The result is a per-CPU target bitmap: each CPU has one bit for each shared interrupt. The pending-delivery logic downstream uses that bitmap to decide which CPU receives a pending shared interrupt.

Slot 0 is the first shared interrupt, which is interrupt number 32 of the controller. The byte offset on the access port divided by 8 gives the slot index. Only the lower 32-bit half of a slot holds data. An affinity value that matches no CPU is still stored and read back. Such an interrupt has no bit set in any CPU bitmap, and its target-valid flag is low. The interrupt can still pend, but it is delivered to no CPU. Every route write produces a one-cycle pulse, so that the delivery logic re-evaluates.

Top module: `aff_router`

## Requirements
- R1: While `rst` is high, every shared interrupt is routed to CPU 0. The stored affinity of every slot takes CPU 0's table entry (bits 31:0 of `cpu_aff_table`). After reset, `tgt_valid` is all ones, the CPU 0 bitmap is all ones, every other CPU bitmap is zero, and `route_upd` is low.
- R2: A read of the lower half of slot s (byte offset 8*s) returns the 32-bit value last written there, unchanged in every bit. The value is packed as Aff0 in bits 7:0, Aff1 in 15:8, Aff2 in 23:16 and Aff3 in 31:24. `acc_rdata` is presented with `acc_rvalid` high in the cycle after the request.
- R3: An access with byte-offset bit 2 set addresses the upper half of a slot. A read of the upper half returns zero. A write to the upper half changes no stored value and no bitmap, and raises no `route_upd`.
- R4: A write whose value equals CPU k's table entry (`cpu_aff_table[32k+31:32k]`) takes effect at the next clock edge. At that edge the interrupt's bit is cleared in its previous target CPU's bitmap and set in CPU k's bitmap, and `tgt_valid` goes high.
- R5: A write whose value matches no CPU entry sets no bit of that interrupt in any bitmap and drives its `tgt_valid` low. The value is still read back as written.
- R6: If several CPU entries equal the written value, the lowest CPU index becomes the target.
- R7: `route_upd` is high for exactly one cycle after each write to the lower half of a slot. It is low after every other cycle's input.
- R8: For every interrupt, at most one CPU bitmap bit is set. `tgt_valid` equals the OR of that interrupt's bits across all CPUs.
- R9: A write to slot s changes only interrupt s. The bitmap bit of CPU c for interrupt s is `tgt_map[c*NUM_SHARED + s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset in the routing region (slot = offset/8, bit 2 = upper half) |
| acc_wdata | input | 32 | Write data (affinity value) |
| acc_rdata | output | 32 | Read data, registered |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cpu_aff_table | input | 32*NUM_CPUS | Affinity value of each CPU, CPU c at bits 32c+31:32c |
| tgt_map | output | NUM_CPUS*NUM_SHARED | Per-CPU target bitmaps, CPU c at bits c*NUM_SHARED upward |
| tgt_valid | output | NUM_SHARED | Interrupt has an existing target CPU |
| route_upd | output | 1 | One-cycle pulse after each route write |

## Verification
The assertions take for granted that `cpu_aff_table` is stable around each write. The target is resolved only at the write edge, so a table change alone must leave the bitmaps unchanged. The assertions also take for granted that an access lasts one cycle, with `acc_we` and `acc_addr` valid whenever `acc_en` is high. The stimulus drives every access as a single-cycle request on the falling edge. It changes the CPU table only while no access is in flight, and it samples outputs on the following falling edge.

// File: rtl/aff_router_pkg.sv
package aff_router_pkg;
  localparam int AFF_W     = 32;
  localparam int CPU_IDX_W = 8;
  typedef logic [CPU_IDX_W-1:0] cpu_idx_t;
  typedef logic [AFF_W-1:0]     aff_t;
  localparam cpu_idx_t CPU_NONE = '1;
endpackage

// File: rtl/aff_matcher.sv
// Parallel affinity compare; the lowest matching CPU index wins.
module aff_matcher
  import aff_router_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic [AFF_W*NUM_CPUS-1:0] cpu_aff_table,
  input  aff_t                      key,
  output cpu_idx_t                  hit_idx
);
  logic [NUM_CPUS-1:0] eq;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cmp
    assign eq[c] = (cpu_aff_table[c*AFF_W +: AFF_W] == key);
  end

  always_comb begin
    hit_idx = CPU_NONE;
    for (int c = NUM_CPUS - 1; c >= 0; c--) begin
      if (eq[c]) hit_idx = cpu_idx_t'(c);
    end
  end
endmodule

// File: rtl/route_store.sv
// Stored affinity per shared interrupt plus registered target bitmaps.
module route_store
  import aff_router_pkg::*;
#(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_SHARED = 32,
  localparam int SLOT_W    = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  aff_t                         rst_aff,
  input  logic                         wr_go,
  input  logic [SLOT_W-1:0]            wr_slot,
  input  aff_t                         wr_aff,
  input  cpu_idx_t                     wr_idx,
  input  logic [SLOT_W-1:0]            rd_slot,
  output aff_t                         rd_aff,
  output logic [NUM_CPUS*NUM_SHARED-1:0] map_q,
  output logic [NUM_SHARED-1:0]        valid_q
);
  aff_t aff_mem [NUM_SHARED];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SHARED; s++) aff_mem[s] <= rst_aff;
    end else if (wr_go) begin
      aff_mem[wr_slot] <= wr_aff;
    end
  end

  assign rd_aff = aff_mem[rd_slot];

  // Clear in the previous CPU and set in the new one happen together:
  // each CPU's bit for the slot takes (new index == that CPU).
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[c*NUM_SHARED +: NUM_SHARED] <= (c == 0) ? '1 : '0;
      end else if (wr_go) begin
        map_q[c*NUM_SHARED + int'(wr_slot)] <= (wr_idx == cpu_idx_t'(c));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '1;
    end else if (wr_go) begin
      valid_q[wr_slot] <= (wr_idx != CPU_NONE);
    end
  end
endmodule

// File: rtl/aff_router.sv
module aff_router
  import aff_router_pkg::*;
#(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_SHARED = 32,
  localparam int SLOT_W    = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1,
  localparam int ADDR_W    = SLOT_W + 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           acc_en,
  input  logic                           acc_we,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic [31:0]                    acc_wdata,
  output logic [31:0]                    acc_rdata,
  output logic                           acc_rvalid,
  input  logic [AFF_W*NUM_CPUS-1:0]      cpu_aff_table,
  output logic [NUM_CPUS*NUM_SHARED-1:0] tgt_map,
  output logic [NUM_SHARED-1:0]          tgt_valid,
  output logic                           route_upd
);
  initial begin
    if (NUM_CPUS < 1 || NUM_CPUS > 255)
      $error("NUM_CPUS must be 1..255");
  end

  logic [SLOT_W-1:0] slot;
  logic              upper_half;
  logic              in_range;
  logic              wr_go;
  cpu_idx_t          hit_idx;
  aff_t              rd_aff;

  assign slot       = acc_addr[ADDR_W-1:3];
  assign upper_half = acc_addr[2];

  if ((1 << SLOT_W) == NUM_SHARED) begin : g_full
    assign in_range = 1'b1;
  end else begin : g_part
    assign in_range = (int'(slot) < NUM_SHARED);
  end

  assign wr_go = acc_en && acc_we && !upper_half && in_range;

  aff_matcher #(.NUM_CPUS(NUM_CPUS)) u_match (
    .cpu_aff_table (cpu_aff_table),
    .key           (acc_wdata),
    .hit_idx       (hit_idx)
  );

  route_store #(.NUM_CPUS(NUM_CPUS), .NUM_SHARED(NUM_SHARED)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rst_aff (cpu_aff_table[AFF_W-1:0]),
    .wr_go   (wr_go),
    .wr_slot (slot),
    .wr_aff  (acc_wdata),
    .wr_idx  (hit_idx),
    .rd_slot (in_range ? slot : '0),
    .rd_aff  (rd_aff),
    .map_q   (tgt_map),
    .valid_q (tgt_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
      route_upd  <= 1'b0;
    end else begin
      acc_rvalid <= acc_en && !acc_we;
      route_upd  <= wr_go;
      if (acc_en && !acc_we)
        acc_rdata <= (!upper_half && in_range) ? rd_aff : '0;
    end
  end
endmodule

// File: rtl/aff_router_chk.sv
module aff_router_chk #(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_SHARED = 32,
  parameter int ADDR_W     = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           acc_en,
  input logic                           acc_we,
  input logic [ADDR_W-1:0]              acc_addr,
  input logic [31:0]                    acc_rdata,
  input logic                           acc_rvalid,
  input logic [NUM_CPUS*NUM_SHARED-1:0] tgt_map,
  input logic [NUM_SHARED-1:0]          tgt_valid,
  input logic                           route_upd
);
  logic lower_wr;
  assign lower_wr = acc_en && acc_we && !acc_addr[2];

  // R7: every lower-half write gives a pulse; nothing else does
  assert_pulse_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    lower_wr |=> route_upd);
  assert_no_spurious_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !lower_wr |=> !route_upd);

  // R3: upper half reads zero
  assert_upper_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we && acc_addr[2]) |=> (acc_rvalid && acc_rdata == 32'h0));

  // R4/R3: bitmaps only move after an accepted route write
  assert_map_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !route_upd |-> $stable(tgt_map));

  for (genvar s = 0; s < NUM_SHARED; s++) begin : g_int
    logic [NUM_CPUS-1:0] col;
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
      assign col[c] = tgt_map[c*NUM_SHARED + s];
    end
    // R8: at most one target, flag agrees with bitmaps
    assert_one_target_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));
    assert_valid_agrees_R8: assert property (@(posedge clk) disable iff (rst)
      tgt_valid[s] == (|col));
  end
endmodule

bind aff_router aff_router_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_SHARED(NUM_SHARED), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
  .tgt_map(tgt_map), .tgt_valid(tgt_valid), .route_upd(route_upd)
);

// File: tb/aff_router_bench.sv
`timescale 1ns/1ps
module aff_router_bench;
  localparam int NC = 4;
  localparam int NS = 32;
  localparam int AW = 8;
  localparam int NONE = 255;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           acc_en = 1'b0, acc_we = 1'b0;
  logic [AW-1:0]  acc_addr = '0;
  logic [31:0]    acc_wdata = '0;
  logic [31:0]    acc_rdata;
  logic           acc_rvalid;
  logic [32*NC-1:0] cpu_aff_table;
  logic [NC*NS-1:0] tgt_map;
  logic [NS-1:0]  tgt_valid;
  logic           route_upd;

  int checks = 0, failures = 0;
  int exp_cpu [NS];
  logic [31:0] exp_aff [NS];

  always #4 clk = ~clk;

  aff_router #(.NUM_CPUS(NC), .NUM_SHARED(NS)) u_aff_router (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .cpu_aff_table(cpu_aff_table),
    .tgt_map(tgt_map), .tgt_valid(tgt_valid), .route_upd(route_upd)
  );

  // vectors: slot, written affinity, expected target CPU (255 = none)
  localparam int          N_VEC = 8;
  localparam int          V_SLOT [N_VEC] = '{5, 5, 0, 31, 9, 9, 31, 5};
  localparam logic [31:0] V_DATA [N_VEC] = '{32'h0000_0011, 32'h0001_0200,
    32'h7F00_0203, 32'h0000_0010, 32'hDEAD_0000, 32'h0000_0011,
    32'h0000_0099, 32'h0001_0200};
  localparam int          V_CPU  [N_VEC] = '{1, 2, 3, 0, NONE, 1, NONE, 2};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_maps(string req);
    for (int c = 0; c < NC; c++) begin
      logic [NS-1:0] e;
      for (int s = 0; s < NS; s++) e[s] = (exp_cpu[s] == c);
      chk(req, tgt_map[c*NS +: NS], e);
    end
    begin
      logic [NS-1:0] v;
      for (int s = 0; s < NS; s++) v[s] = (exp_cpu[s] != NONE);
      chk(req, tgt_valid, v);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    d = acc_rdata;
    chk("R2 rvalid", {31'b0, acc_rvalid}, 32'h1);
  endtask

  task automatic do_reset(logic [31:0] cpu0_aff);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < NS; s++) begin
      exp_cpu[s] = 0;
      exp_aff[s] = cpu0_aff;
    end
  endtask

  initial begin
    logic [31:0] r;
    cpu_aff_table = {32'h7F00_0203, 32'h0001_0200, 32'h0000_0011, 32'h0000_0010};
    do_reset(32'h0000_0010);
    @(negedge clk);
    // R1: reset state
    chk_maps("R1 reset bitmaps");
    chk("R1 no pulse", {31'b0, route_upd}, 32'h0);
    rd(8'd3 << 3, r);
    chk("R1 reset affinity", r, 32'h0000_0010);

    // table walk: R4 R5 R9 R2 R7
    for (int i = 0; i < N_VEC; i++) begin
      wr(AW'(V_SLOT[i] * 8), V_DATA[i]);
      exp_cpu[V_SLOT[i]] = V_CPU[i];
      exp_aff[V_SLOT[i]] = V_DATA[i];
      chk("R7 pulse after write", {31'b0, route_upd}, 32'h1);
      chk_maps((V_CPU[i] == NONE) ? "R5 no-match bitmaps" : "R4/R9 bitmaps");
      @(negedge clk);
      chk("R7 pulse one cycle", {31'b0, route_upd}, 32'h0);
      rd(AW'(V_SLOT[i] * 8), r);
      chk("R2/R5 readback as written", r, V_DATA[i]);
    end

    // R3: upper half ignores writes, reads zero
    wr(8'd5 * 8 + 8'd4, 32'h0000_0010);
    chk("R3 no pulse on upper write", {31'b0, route_upd}, 32'h0);
    chk_maps("R3 bitmaps unchanged");
    rd(8'd5 * 8 + 8'd4, r);
    chk("R3 upper reads zero", r, 32'h0);
    rd(8'd5 * 8, r);
    chk("R3 lower unchanged", r, 32'h0001_0200);

    // R6: duplicate affinity, lowest index wins
    @(negedge clk);
    cpu_aff_table[3*32 +: 32] = 32'h0000_0011;
    wr(8'd12 * 8, 32'h0000_0011);
    exp_cpu[12] = 1;
    chk_maps("R6 lowest index wins");

    // R1: reset takes CPU 0's current affinity
    cpu_aff_table[31:0] = 32'h0000_0055;
    do_reset(32'h0000_0055);
    @(negedge clk);
    chk_maps("R1 re-reset bitmaps");
    rd(8'd20 * 8, r);
    chk("R1 re-reset affinity", r, 32'h0000_0055);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule